// File: doc/BRIEF.md
# Linked-Table Address Translator

This block sits between a trace-buffer writer and memory. It converts a linear input address into a physical address by consulting 4 KB translation tables that live in memory and are chained to one another in both directions. Each table covers one 1 MB slice of input space with up to 256 page pointers. Entry 510 links back to the previous table and entry 511 links forward to the next one. The block remembers one table and the index of its 1 MB slice. When a request lands in another slice, it walks the chain one link at a time until it reaches the wanted table, then fetches the page pointer.

Software sets up the block through a small register port. It writes the mode, the table base and the input base while the block is disabled, then sets the enable bit. It polls a ready status bit around enable and disable. In pass-through mode, addresses go straight out and no table is read. The request port holds ready low from acceptance until a translated address or a fault has been returned. The memory read port is a request/acknowledge pair that returns one 64-bit entry per read.

Top module: `chain_xlat`

## Requirements
- R1: After reset the block is disabled. The status register (index 4, bit 0) reads 1. The control register (index 0) reads 0. `reqReady` and `memReq` are low.
- R2: The ID register (index 5) returns the physical address width `PA_W` in bits 5:0.
- R3: While the enable bit (control bit 0) is clear, `reqReady` stays low, no request is accepted, no response is produced and no memory read is made.
- R4: In pass-through mode (mode register index 1, bit 0 = 0), `rspValid` rises in the cycle after acceptance. `rspAddr` equals the input address zero-extended, `rspFault` is 0, and no memory read is made.
- R5: In translate mode (mode bit 0 = 1), for a request in the current 1 MB slice, one read is made at address `table + 8*idx`, where idx is bits 19:12 of (address − input base). The result is entry bits PA_W−1:12 joined to input bits 11:0. Entry bits 11:1 and the bits above PA_W have no effect.
- R6: A page pointer with bit 0 clear produces `rspFault` = 1 and `rspAddr` = 0.
- R7: A request for a later slice follows entry 511, and a request for an earlier slice follows entry 510. Each step costs one read, and the final pointer read adds one more. The reached table is kept for later requests. Setting the enable bit from disabled returns the walk position to the table base, slice 0.
- R8: A link with bit 0 clear ends the walk with a fault, and the position stays at the last valid table.
- R9: An input address below the input base faults with no memory read.
- R10: The table base (register index 2) keeps bits PA_W−1:12 only, and the input base (index 3) keeps bits IA_W−1:20 only. The dropped bits read back as 0 and do not affect lookups.
- R11: Writes to the mode, table base and input base registers are ignored while the block is enabled.
- R12: Clearing the enable bit during a walk abandons the request with no response. While a read is still outstanding, status ready reads 0 and `memReq` stays high until `memAck`. After that, ready reads 1.
- R13: `memReq`, once raised, stays high with a stable `memAddr` until `memAck`, and `rspValid` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWdata | input | 64 | Register write data |
| regRdata | output | 64 | Register read data for regAddr |
| reqValid | input | 1 | Translation request present |
| reqAddr | input | IA_W | Linear input address |
| reqReady | output | 1 | Request accepted when high with reqValid |
| rspValid | output | 1 | One-cycle response strobe |
| rspAddr | output | PA_W | Translated or passed-through address |
| rspFault | output | 1 | Lookup failed |
| memReq | output | 1 | Table entry read request |
| memAddr | output | PA_W | Byte address of the entry |
| memAck | input | 1 | Read data valid |
| memData | input | 64 | Table entry returned |

## Verification
Some properties are checked on every cycle: the memory request holding its address until acknowledged, single-cycle responses, page offsets carried through, the walk position moving at most one slice per cycle, and the absence of reads for below-base or pass-through traffic. The bench scenarios are needed for the rest. They show the read counts for forward and backward walks, faults from invalid pointers and broken links, and register masking and write blocking while enabled. They also cover the abandon-on-disable sequence, where the ready status only returns after the late acknowledge.

// File: rtl/chain_xlat_pkg.sv
package chain_xlat_pkg;
  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_MODE  = 3'd1;
  localparam logic [2:0] RA_TBASE = 3'd2;
  localparam logic [2:0] RA_IBASE = 3'd3;
  localparam logic [2:0] RA_STAT  = 3'd4;
  localparam logic [2:0] RA_ID    = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_SEEK, ST_RESP, ST_DRAIN} ctrlState_t;

  typedef struct packed {
    logic latchReq;
    logic loadPass;
    logic stepNext;
    logic stepPrev;
    logic loadLeaf;
    logic setFault;
  } xlatStrobes_t;
endpackage

// File: rtl/chain_xlat_regs.sv
module chain_xlat_regs
  import chain_xlat_pkg::*;
#(
  parameter int PA_W = 40,
  parameter int IA_W = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int REGION_SHIFT = 20
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWe,
  input  logic [2:0]      regAddr,
  input  logic [63:0]     regWdata,
  input  logic            statusReady,
  output logic [63:0]     regRdata,
  output logic            enable,
  output logic            modeXlat,
  output logic [PA_W-1:0] tableBase,
  output logic [IA_W-1:0] inBase,
  output logic            reloadBase
);
  logic cfgOpen;
  logic unusedWr;

  assign cfgOpen = regWe && !enable;
  assign reloadBase = regWe && (regAddr == RA_CTRL) && regWdata[0] && !enable;
  assign unusedWr = ^regWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable    <= 1'b0;
      modeXlat  <= 1'b0;
      tableBase <= '0;
      inBase    <= '0;
    end else begin
      if (regWe && regAddr == RA_CTRL) enable <= regWdata[0];
      if (cfgOpen && regAddr == RA_MODE) modeXlat <= regWdata[0];
      if (cfgOpen && regAddr == RA_TBASE)
        tableBase <= {regWdata[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      if (cfgOpen && regAddr == RA_IBASE)
        inBase <= {regWdata[IA_W-1:REGION_SHIFT], {REGION_SHIFT{1'b0}}};
    end
  end

  always_comb begin
    unique case (regAddr)
      RA_CTRL:  regRdata = {63'd0, enable};
      RA_MODE:  regRdata = {63'd0, modeXlat};
      RA_TBASE: regRdata = 64'(tableBase);
      RA_IBASE: regRdata = 64'(inBase);
      RA_STAT:  regRdata = {63'd0, statusReady};
      RA_ID:    regRdata = {58'd0, 6'(PA_W)};
      default:  regRdata = 64'd0;
    endcase
  end

  // R11
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    enable && $past(enable) |-> $stable(tableBase) && $stable(inBase) && $stable(modeXlat));
endmodule

// File: rtl/chain_xlat_ctrl.sv
module chain_xlat_ctrl
  import chain_xlat_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         modeXlat,
  input  logic         reqValid,
  input  logic         memAck,
  input  logic         entryValid,
  input  logic         belowBase,
  input  logic         tgtAhead,
  input  logic         tgtBehind,
  output logic         reqReady,
  output logic         memReq,
  output logic         rspValid,
  output logic         statusReady,
  output xlatStrobes_t strb
);
  ctrlState_t state, nxt;

  always_comb begin
    strb     = '0;
    nxt      = state;
    reqReady = 1'b0;
    memReq   = 1'b0;
    rspValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = enable;
        if (enable && reqValid) begin
          strb.latchReq = 1'b1;
          if (modeXlat) nxt = ST_SEEK;
          else begin
            strb.loadPass = 1'b1;
            nxt = ST_RESP;
          end
        end
      end
      ST_SEEK: begin
        memReq = !belowBase;
        if (!enable) begin
          nxt = (belowBase || memAck) ? ST_IDLE : ST_DRAIN;
        end else if (belowBase) begin
          strb.setFault = 1'b1;
          nxt = ST_RESP;
        end else if (memAck) begin
          if (tgtAhead || tgtBehind) begin
            if (entryValid) begin
              strb.stepNext = tgtAhead;
              strb.stepPrev = tgtBehind;
            end else begin
              strb.setFault = 1'b1;
              nxt = ST_RESP;
            end
          end else begin
            strb.loadLeaf = entryValid;
            strb.setFault = !entryValid;
            nxt = ST_RESP;
          end
        end
      end
      ST_RESP: begin
        rspValid = 1'b1;
        nxt = ST_IDLE;
      end
      ST_DRAIN: begin
        memReq = 1'b1;
        if (memAck) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign statusReady = !memReq;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nxt;
  end

  // R13
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);
  // R12
  drain_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable && $past(!enable) |-> !rspValid);
endmodule

// File: rtl/chain_xlat_dp.sv
module chain_xlat_dp
  import chain_xlat_pkg::*;
#(
  parameter int PA_W = 40,
  parameter int IA_W = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int REGION_SHIFT = 20
) (
  input  logic            clk,
  input  logic            rstN,
  input  xlatStrobes_t    strb,
  input  logic            reloadBase,
  input  logic [PA_W-1:0] tableBase,
  input  logic [IA_W-1:0] inBase,
  input  logic [IA_W-1:0] reqAddr,
  input  logic            rspValid,
  input  logic [63:0]     memData,
  output logic [PA_W-1:0] memAddr,
  output logic [PA_W-1:0] rspAddr,
  output logic            rspFault,
  output logic            belowBase,
  output logic            tgtAhead,
  output logic            tgtBehind,
  output logic            entryValid
);
  localparam int IDX_W   = REGION_SHIFT - PAGE_SHIFT;
  localparam int ENT_W   = PAGE_SHIFT - 3;
  localparam int RGN_W   = IA_W - REGION_SHIFT;
  localparam int FRAME_W = PA_W - PAGE_SHIFT;
  localparam logic [ENT_W-1:0] LINK_NEXT = {ENT_W{1'b1}};
  localparam logic [ENT_W-1:0] LINK_PREV = ENT_W'(LINK_NEXT - 1'b1);

  logic [IA_W-1:0]    reqAddrQ;
  logic [FRAME_W-1:0] curFrame;
  logic [RGN_W-1:0]   curRegion;
  logic [IA_W-1:0]    offset;
  logic [RGN_W-1:0]   tgtRegion;
  logic [IDX_W-1:0]   leafIdx;
  logic [ENT_W-1:0]   entSel;
  logic               unusedDp;

  assign offset    = reqAddrQ - inBase;
  assign tgtRegion = offset[IA_W-1:REGION_SHIFT];
  assign leafIdx   = offset[REGION_SHIFT-1:PAGE_SHIFT];
  assign belowBase = reqAddrQ < inBase;
  assign tgtAhead  = tgtRegion > curRegion;
  assign tgtBehind = tgtRegion < curRegion;
  assign entryValid = memData[0];
  assign unusedDp  = ^{memData, tableBase};

  always_comb begin
    if (tgtAhead) entSel = LINK_NEXT;
    else if (tgtBehind) entSel = LINK_PREV;
    else entSel = {{(ENT_W-IDX_W){1'b0}}, leafIdx};
  end

  assign memAddr = {curFrame, entSel, 3'b000};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddrQ  <= '0;
      curFrame  <= '0;
      curRegion <= '0;
      rspAddr   <= '0;
      rspFault  <= 1'b0;
    end else begin
      if (reloadBase) begin
        curFrame  <= tableBase[PA_W-1:PAGE_SHIFT];
        curRegion <= '0;
      end else if (strb.stepNext) begin
        curFrame  <= memData[PA_W-1:PAGE_SHIFT];
        curRegion <= curRegion + RGN_W'(1);
      end else if (strb.stepPrev) begin
        curFrame  <= memData[PA_W-1:PAGE_SHIFT];
        curRegion <= curRegion - RGN_W'(1);
      end
      if (strb.latchReq) reqAddrQ <= reqAddr;
      if (strb.loadPass) begin
        rspAddr  <= PA_W'(reqAddr);
        rspFault <= 1'b0;
      end else if (strb.loadLeaf) begin
        rspAddr  <= {memData[PA_W-1:PAGE_SHIFT], reqAddrQ[PAGE_SHIFT-1:0]};
        rspFault <= 1'b0;
      end else if (strb.setFault) begin
        rspAddr  <= '0;
        rspFault <= 1'b1;
      end
    end
  end

  // R7
  region_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reloadBase |=> (curRegion == $past(curRegion)) ||
                    (curRegion == $past(curRegion) + RGN_W'(1)) ||
                    (curRegion == $past(curRegion) - RGN_W'(1)));
  // R5
  leaf_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> rspAddr[PAGE_SHIFT-1:0] == reqAddrQ[PAGE_SHIFT-1:0]);
endmodule

// File: rtl/chain_xlat.sv
module chain_xlat
  import chain_xlat_pkg::*;
#(
  parameter int PA_W = 40,
  parameter int IA_W = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int REGION_SHIFT = 20
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWe,
  input  logic [2:0]      regAddr,
  input  logic [63:0]     regWdata,
  output logic [63:0]     regRdata,
  input  logic            reqValid,
  input  logic [IA_W-1:0] reqAddr,
  output logic            reqReady,
  output logic            rspValid,
  output logic [PA_W-1:0] rspAddr,
  output logic            rspFault,
  output logic            memReq,
  output logic [PA_W-1:0] memAddr,
  input  logic            memAck,
  input  logic [63:0]     memData
);
  logic enable, modeXlat, reloadBase, statusReady;
  logic belowBase, tgtAhead, tgtBehind, entryValid;
  logic [PA_W-1:0] tableBase;
  logic [IA_W-1:0] inBase;
  xlatStrobes_t strb;

  chain_xlat_regs #(.PA_W(PA_W), .IA_W(IA_W), .PAGE_SHIFT(PAGE_SHIFT), .REGION_SHIFT(REGION_SHIFT)) u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .statusReady(statusReady), .regRdata(regRdata), .enable(enable), .modeXlat(modeXlat),
    .tableBase(tableBase), .inBase(inBase), .reloadBase(reloadBase));

  chain_xlat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .modeXlat(modeXlat), .reqValid(reqValid),
    .memAck(memAck), .entryValid(entryValid), .belowBase(belowBase), .tgtAhead(tgtAhead),
    .tgtBehind(tgtBehind), .reqReady(reqReady), .memReq(memReq), .rspValid(rspValid),
    .statusReady(statusReady), .strb(strb));

  chain_xlat_dp #(.PA_W(PA_W), .IA_W(IA_W), .PAGE_SHIFT(PAGE_SHIFT), .REGION_SHIFT(REGION_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reloadBase(reloadBase), .tableBase(tableBase),
    .inBase(inBase), .reqAddr(reqAddr), .rspValid(rspValid), .memData(memData),
    .memAddr(memAddr), .rspAddr(rspAddr), .rspFault(rspFault), .belowBase(belowBase),
    .tgtAhead(tgtAhead), .tgtBehind(tgtBehind), .entryValid(entryValid));

  // R13
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr));
  // R9
  below_noread_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !belowBase);
  // R4
  pass_noread_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && enable |-> modeXlat);
endmodule

// File: tb/chain_xlat_tb.sv
`timescale 1ns/1ps
module chain_xlat_tb;
  localparam logic [31:0] BASE = 32'h1000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [63:0] regWdata = 64'd0;
  logic [63:0] regRdata;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = 32'd0;
  logic reqReady, rspValid, rspFault, memReq;
  logic [39:0] rspAddr, memAddr;
  logic memAck;
  logic [63:0] memData;

  int checks = 0, fails = 0;
  int readCount = 0, rspCount = 0;
  int memLat = 0, cnt = 0;
  int curR = 0;
  logic [63:0] memArr [logic [39:0]];

  always #4 clk = ~clk;

  chain_xlat u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .reqValid(reqValid), .reqAddr(reqAddr), .reqReady(reqReady),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspFault(rspFault), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .memData(memData));

  function automatic logic [39:0] tblAddr(input int t);
    return 40'h01_0000_0000 + 40'(t) * 40'h3000;
  endfunction
  function automatic logic [39:0] pageAddr(input int r, input int i);
    return 40'h20_0000_0000 + 40'(r * 256 + i) * 40'h1000;
  endfunction
  function automatic bit badPtr(input int r, input int i);
    return ((r * 256 + i) % 29) == 7;
  endfunction
  function automatic logic [63:0] memRead(input logic [39:0] a);
    return memArr.exists(a) ? memArr[a] : 64'd0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0; memData <= 64'd0; cnt <= 0;
    end else if (memAck) begin
      memAck <= 1'b0; cnt <= memLat;
    end else if (memReq) begin
      if (cnt == 0) begin memAck <= 1'b1; memData <= memRead(memAddr); end
      else cnt <= cnt - 1;
    end
  end

  always @(posedge clk) begin
    if (memReq && memAck) readCount <= readCount + 1;
    if (rspValid) rspCount <= rspCount + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic doReq(input logic [31:0] a, output logic [39:0] pa, output logic f,
                       output int reads, output int lat);
    int n, r0;
    r0 = readCount;
    @(negedge clk); reqValid = 1'b1; reqAddr = a;
    n = 0;
    while (!reqReady && n < 100) begin @(negedge clk); n++; end
    @(negedge clk); reqValid = 1'b0;
    lat = 0;
    while (!rspValid && lat < 300) begin @(negedge clk); lat++; end
    pa = rspAddr; f = rspFault; reads = readCount - r0;
  endtask

  task automatic model(input logic [31:0] a, input logic [31:0] base,
                       output logic f, output logic [39:0] pa, output int nReads);
    logic [31:0] off;
    int r, idx;
    if (a < base) begin f = 1; pa = 0; nReads = 0; return; end
    off = a - base; r = int'(off >> 20); idx = int'(off[19:12]);
    if (r > 3) begin
      nReads = (3 - curR) + 1; curR = 3; f = 1; pa = 0;
    end else begin
      nReads = ((r > curR) ? r - curR : curR - r) + 1; curR = r;
      if (badPtr(r, idx)) begin f = 1; pa = 0; end
      else begin f = 0; pa = pageAddr(r, idx) | 40'(a[11:0]); end
    end
  endtask

  task automatic xlatCheck(input logic [31:0] a, input logic [31:0] base, input string tag);
    logic [39:0] pa, epa; logic f, ef; int rd, erd, lat;
    model(a, base, ef, epa, erd);
    doReq(a, pa, f, rd, lat);
    chk(lat < 300, tag, "response arrived", 64'(lat), 64'd0);
    chk(f == ef, tag, "fault", 64'(f), 64'(ef));
    chk(pa == epa, tag, "address", 64'(pa), 64'(epa));
    chk(rd == erd, tag, "read count", 64'(rd), 64'(erd));
  endtask

  task automatic restart(input logic mode, input logic [63:0] tb, input logic [63:0] ib);
    wrReg(3'd0, 64'd0);
    wrReg(3'd1, 64'(mode));
    wrReg(3'd2, tb);
    wrReg(3'd3, ib);
    wrReg(3'd0, 64'd1);
    curR = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R13 watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] d; logic [39:0] pa; logic f; int rd, lat, r0, q0;
    void'($urandom(32'd4711));
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < 256; i++) begin
        logic [39:0] p;
        p = pageAddr(t, i);
        memArr[tblAddr(t) + 40'(i * 8)] = {24'hA5C3E1, p[39:12], 11'h5AA, !badPtr(t, i)};
      end
      memArr[tblAddr(t) + 40'(510 * 8)] = (t > 0) ? {24'd0, tblAddr(t-1)} | 64'd1
                                                  : {24'd0, 28'h1234567, 12'h000};
      memArr[tblAddr(t) + 40'(511 * 8)] = (t < 3) ? {24'd0, tblAddr(t+1)} | 64'd1
                                                  : {24'd0, 28'h7654321, 12'h000};
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdReg(3'd0, d); chk(d == 0, "R1", "control after reset", d, 0);
    rdReg(3'd4, d); chk(d[0] == 1'b1, "R1", "ready after reset", d, 1);
    chk(!reqReady && !memReq, "R1", "reqReady/memReq after reset", {reqReady, memReq}, 0);
    // R2 id
    rdReg(3'd5, d); chk(d[5:0] == 6'd40, "R2", "address width id", d[5:0], 40);
    // R3 disabled ignores requests
    r0 = readCount; q0 = rspCount;
    @(negedge clk); reqValid = 1'b1; reqAddr = BASE;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); chk(!reqReady, "R3", "reqReady while disabled", reqReady, 0);
    end
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
    chk(rspCount == q0 && readCount == r0, "R3", "no response or read while disabled",
        64'(rspCount - q0 + readCount - r0), 0);
    // R4 pass-through
    restart(1'b0, 64'(tblAddr(0)), 64'(BASE));
    for (int k = 0; k < 6; k++) begin
      logic [31:0] a;
      a = $urandom;
      doReq(a, pa, f, rd, lat);
      chk(lat == 0, "R4", "pass latency", 64'(lat), 0);
      chk(pa == 40'(a) && !f, "R4", "pass address", 64'(pa), 64'(a));
      chk(rd == 0, "R4", "pass reads", 64'(rd), 0);
    end
    // translate mode
    restart(1'b1, 64'(tblAddr(0)), 64'(BASE));
    xlatCheck(BASE + 32'h0000_3ABC, BASE, "R5");
    xlatCheck(BASE + 32'h0000_0123, BASE, "R5");
    xlatCheck(BASE + 32'h0000_7010, BASE, "R6");            // pointer 7 of slice 0 invalid
    xlatCheck(BASE + 32'h0030_2FFF, BASE, "R7");            // forward 3 slices
    xlatCheck(BASE + 32'h0010_1004, BASE, "R7");            // back 2 slices
    xlatCheck(BASE + 32'h0010_2008, BASE, "R7");            // same slice kept
    xlatCheck(BASE + 32'h0050_0000, BASE, "R8");            // broken forward link
    xlatCheck(BASE + 32'h0020_4000, BASE, "R8");            // position kept at slice 3
    xlatCheck(BASE - 32'h0000_0010, BASE, "R9");
    // R11 writes blocked while enabled
    wrReg(3'd3, 64'h5000_0000); wrReg(3'd1, 64'd0);
    rdReg(3'd3, d); chk(d == 64'(BASE), "R11", "input base locked", d, 64'(BASE));
    rdReg(3'd1, d); chk(d == 64'd1, "R11", "mode locked", d, 1);
    xlatCheck(BASE + 32'h0000_1040, BASE, "R11");
    // R10 masking; R7 enable resets walk position
    wrReg(3'd0, 64'd0);
    wrReg(3'd2, 64'(tblAddr(0)) | 64'hABC);
    wrReg(3'd3, 64'h0030_5678);
    rdReg(3'd2, d); chk(d == 64'(tblAddr(0)), "R10", "table base mask", d, 64'(tblAddr(0)));
    rdReg(3'd3, d); chk(d == 64'h0030_0000, "R10", "input base mask", d, 64'h0030_0000);
    wrReg(3'd0, 64'd1); curR = 0;
    xlatCheck(32'h0030_0000 + 32'h0010_5123, 32'h0030_0000, "R10");
    restart(1'b1, 64'(tblAddr(0)), 64'(BASE));
    // random traffic
    for (int k = 0; k < 80; k++) begin
      logic [31:0] a;
      if ($urandom % 10 == 0) a = BASE - 32'd1 - ($urandom % 4096);
      else a = BASE + (($urandom % 6) << 20) + (($urandom % 256) << 12) + ($urandom % 4096);
      xlatCheck(a, BASE, "R5/R6/R7/R8/R9");
    end
    // R12 disable during a walk
    memLat = 8;
    xlatCheck(BASE + 32'h0000_0008, BASE, "R12");
    restart(1'b1, 64'(tblAddr(0)), 64'(BASE));
    q0 = rspCount;
    @(negedge clk); reqValid = 1'b1; reqAddr = BASE + 32'h0030_0000;
    while (!reqReady) @(negedge clk);
    @(negedge clk); reqValid = 1'b0;
    @(negedge clk);
    wrReg(3'd0, 64'd0);
    rdReg(3'd4, d); chk(d[0] == 1'b0, "R12", "ready low with read outstanding", d, 0);
    chk(memReq, "R12", "memReq held after disable", memReq, 1);
    lat = 0;
    do begin rdReg(3'd4, d); lat++; end while (d[0] == 1'b0 && lat < 40);
    chk(d[0] == 1'b1, "R12", "ready after drain", d, 1);
    chk(!memReq && !reqReady, "R12", "idle after drain", {memReq, reqReady}, 0);
    repeat (3) @(negedge clk);
    chk(rspCount == q0, "R12", "no response for abandoned request", 64'(rspCount - q0), 0);
    memLat = 1;
    restart(1'b1, 64'(tblAddr(0)), 64'(BASE));
    xlatCheck(BASE + 32'h0020_1ABC, BASE, "R12");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule